// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the one-cycle completion pulses of a set of DMA channels (16 by default) into a raw status register, one bit per channel. From that register it derives two independent interrupt lines. Each line has its own enable mask and its own force register. The force bits are ORed with the raw bits before the mask is applied, so software can raise a request on one line without touching the other line or the raw status.

A channel can be placed in quiet mode through its `ch_quiet` input. Completion pulses from a quiet channel never reach the raw status. Software reaches every register through a small word-addressed bus: writes take effect on the clock edge, and reads are combinational. Raw bits are cleared by writing ones, either to the raw register or to either masked-status register. Reading a register never changes any state.

Register map (`bus_addr`): 0 raw status; for line k (k = 0, 1) the base is 1+3k. Base+0 is the enable mask, base+1 is the force register, and base+2 is the masked status. This gives 1/2/3 for line 0 and 4/5/6 for line 1. Address 7 is unused.

Top module: `dmairq_agg`

## Requirements
- R1: While `rst` is high, and on the first clock after it, all registers read 0 and both `irq_line` bits are 0.
- R2: A `ch_done` pulse on channel n while `ch_quiet[n]` is 0 sets raw bit n at the next clock edge. The bit stays set until it is cleared.
- R3: A `ch_done` pulse on channel n while `ch_quiet[n]` is 1 leaves raw bit n unchanged.
- R4: Writing a value to address 0 clears every raw bit whose data bit is 1 and leaves the other raw bits unchanged.
- R5: Writing a value to a masked-status address (3 or 6) clears raw bits in the same way as R4. It changes no enable or force register.
- R6: If a qualifying completion pulse and a write-one clear hit the same raw bit in the same cycle, the bit is set after the edge.
- R7: Reading the masked-status address of line k returns (raw OR force_k) AND enable_k.
- R8: `irq_line[k]` is 1 exactly when the masked status of line k is non-zero.
- R9: Force bits change only on a write to their own force address. They never alter the raw status.
- R10: The enable and force registers read back the last value written. Address 7 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_quiet | input | NUM_CH | Per-channel quiet mode; blocks posting to raw status |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | NUM_CH | Register write data |
| bus_rdata | output | NUM_CH | Combinational read data for `bus_addr` |
| irq_line | output | NUM_LINES | Interrupt outputs, one per line |

## Verification
The assertions assume that `rst` is high during the first clock edge. They also assume that `ch_done` and `ch_quiet` are stable around the edge, so that a completion seen on an edge is judged against the quiet bit of that same edge. The stimulus changes every input only on falling edges. It holds `rst` for several cycles before the first operation. It keeps `ch_quiet` constant across every pulse it issues, and changes it only between sweeps.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Slot of a register inside one line's group of three addresses
    typedef enum logic [1:0] {
        SLOT_EN  = 2'd0,
        SLOT_FRC = 2'd1,
        SLOT_MSK = 2'd2
    } line_slot_e;

    localparam int RAW_ADDR   = 0;
    localparam int LINE_SPAN  = 3;

    // First address of line k's register group
    function automatic int line_base(input int k);
        return 1 + LINE_SPAN * k;
    endfunction

    // Address width needed to reach every register of n lines
    function automatic int addr_width(input int n);
        return (1 + LINE_SPAN * n) > 1 ? $clog2(1 + LINE_SPAN * n) : 1;
    endfunction

    // Write strobes decoded for one line
    typedef struct packed {
        logic en_we;
        logic frc_we;
        logic msk_hit;
    } line_wr_t;

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = 3
) (
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       raw_hit,
    output line_wr_t [NUM_LINES-1:0]   line_wr,
    output logic                       clr_hit
);

    logic [NUM_LINES-1:0] msk_any;

    assign raw_hit = wr && (addr == ADDR_W'(RAW_ADDR));

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_line
            assign line_wr[k].en_we   = wr && (addr == ADDR_W'(line_base(k) + int'(SLOT_EN)));
            assign line_wr[k].frc_we  = wr && (addr == ADDR_W'(line_base(k) + int'(SLOT_FRC)));
            assign line_wr[k].msk_hit = wr && (addr == ADDR_W'(line_base(k) + int'(SLOT_MSK)));
            assign msk_any[k]         = line_wr[k].msk_hit;
        end
    endgenerate

    // Raw bits are cleared by writes to raw or to any masked view
    assign clr_hit = raw_hit || (|msk_any);

endmodule

// File: rtl/dmairq_raw.sv
module dmairq_raw #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] quiet,
    input  logic              clr_hit,
    input  logic [NUM_CH-1:0] clr_bits,
    output logic [NUM_CH-1:0] raw_q
);

    logic [NUM_CH-1:0] post;
    logic [NUM_CH-1:0] clr;

    assign post = done & ~quiet;
    assign clr  = clr_hit ? clr_bits : '0;

    // Setting takes precedence over clearing on the same bit
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr) | post;
    end

endmodule

// File: rtl/dmairq_line.sv
module dmairq_line #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              frc_we,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] frc_q,
    output logic [NUM_CH-1:0] masked,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            frc_q <= '0;
        end else begin
            if (en_we)  en_q  <= wdata;
            if (frc_we) frc_q <= wdata;
        end
    end

    assign masked = (raw | frc_q) & en_q;
    assign irq    = |masked;

endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
    import dmairq_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = addr_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    ch_done,
    input  logic [NUM_CH-1:0]    ch_quiet,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_CH-1:0]    bus_wdata,
    output logic [NUM_CH-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_line
);

    logic                                raw_hit;
    logic                                clr_hit;
    line_wr_t [NUM_LINES-1:0]            line_wr;
    logic [NUM_CH-1:0]                   raw_q;
    logic [NUM_LINES-1:0][NUM_CH-1:0]    en_q;
    logic [NUM_LINES-1:0][NUM_CH-1:0]    frc_q;
    logic [NUM_LINES-1:0][NUM_CH-1:0]    masked;

    dmairq_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .raw_hit (raw_hit),
        .line_wr (line_wr),
        .clr_hit (clr_hit)
    );

    dmairq_raw #(.NUM_CH(NUM_CH)) u_raw (
        .clk      (clk),
        .rst      (rst),
        .done     (ch_done),
        .quiet    (ch_quiet),
        .clr_hit  (clr_hit),
        .clr_bits (bus_wdata),
        .raw_q    (raw_q)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_line
            dmairq_line #(.NUM_CH(NUM_CH)) u_line (
                .clk    (clk),
                .rst    (rst),
                .en_we  (line_wr[k].en_we),
                .frc_we (line_wr[k].frc_we),
                .wdata  (bus_wdata),
                .raw    (raw_q),
                .en_q   (en_q[k]),
                .frc_q  (frc_q[k]),
                .masked (masked[k]),
                .irq    (irq_line[k])
            );
        end
    endgenerate

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(RAW_ADDR)) bus_rdata = raw_q;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (bus_addr == ADDR_W'(line_base(j) + int'(SLOT_EN)))  bus_rdata = en_q[j];
            if (bus_addr == ADDR_W'(line_base(j) + int'(SLOT_FRC))) bus_rdata = frc_q[j];
            if (bus_addr == ADDR_W'(line_base(j) + int'(SLOT_MSK))) bus_rdata = masked[j];
        end
    end

endmodule

// File: rtl/dmairq_agg_chk.sv
module dmairq_agg_chk #(
    parameter int NUM_CH    = 16,
    parameter int NUM_LINES = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_CH-1:0]                ch_done,
    input logic [NUM_CH-1:0]                ch_quiet,
    input logic                             bus_wr,
    input logic [NUM_CH-1:0]                bus_wdata,
    input logic                             clr_hit,
    input logic [NUM_CH-1:0]                raw_q,
    input logic [NUM_LINES-1:0][NUM_CH-1:0] en_q,
    input logic [NUM_LINES-1:0][NUM_CH-1:0] frc_q,
    input logic [NUM_LINES-1:0]             irq_line
);

    // R1: reset empties raw status and silences the lines
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (raw_q == '0) && (irq_line == '0));

    // R2: a qualifying pulse is visible in raw status after the edge
    assert_post_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ((ch_done & ~ch_quiet) != '0) |=>
            ((raw_q & $past(ch_done & ~ch_quiet)) == $past(ch_done & ~ch_quiet)));

    // R3: newly set raw bits only come from non-quiet pulses
    assert_quiet_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ch_done & ~ch_quiet)) == '0));

    // R4: a clear write without competing pulses drops the written bits
    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && (ch_done == '0)) |=> ((raw_q & $past(bus_wdata)) == '0));

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_chk
            // R8: line output follows the masked request set
            assert_line_or_R8: assert property (@(posedge clk) disable iff (rst)
                irq_line[k] == (|((raw_q | frc_q[k]) & en_q[k])));
            // R9: force holds its value when no write occurs
            assert_force_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !bus_wr |=> $stable(frc_q[k]));
        end
    endgenerate

endmodule

bind dmairq_agg dmairq_agg_chk #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ch_done   (ch_done),
    .ch_quiet  (ch_quiet),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .clr_hit   (clr_hit),
    .raw_q     (raw_q),
    .en_q      (en_q),
    .frc_q     (frc_q),
    .irq_line  (irq_line)
);

// File: tb/dmairq_agg_tb.sv
module dmairq_agg_tb_top;

    localparam int NCH = 16;
    localparam int NL  = 2;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_quiet = '0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [NCH-1:0] bus_wdata = '0;
    logic [NCH-1:0] bus_rdata;
    logic [NL-1:0]  irq_line;

    int checks = 0;
    int fails  = 0;

    logic [NCH-1:0] m_raw = '0;
    logic [NCH-1:0] m_en [NL];
    logic [NCH-1:0] m_frc [NL];

    always #5 clk = ~clk;

    dmairq_agg #(.NUM_CH(NCH), .NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst), .ch_done(ch_done), .ch_quiet(ch_quiet),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_line(irq_line)
    );

    task automatic chk(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [NCH-1:0] m_mask(input int k);
        return (m_raw | m_frc[k]) & m_en[k];
    endfunction

    function automatic logic [NCH-1:0] m_read(input int a);
        case (a)
            0: return m_raw;
            1: return m_en[0];
            2: return m_frc[0];
            3: return m_mask(0);
            4: return m_en[1];
            5: return m_frc[1];
            6: return m_mask(1);
            default: return '0;
        endcase
    endfunction

    // Read every address and both lines, compare against the model
    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            bus_addr = AW'(a);
            #1;
            if (a == 0)               chk({tag, " raw"}, bus_rdata, m_read(a));
            else if (a == 3 || a == 6) chk($sformatf("R7 masked addr %0d", a), bus_rdata, m_read(a));
            else                      chk($sformatf("R10 readback addr %0d", a), bus_rdata, m_read(a));
        end
        for (int k = 0; k < NL; k++)
            chk($sformatf("R8 irq line %0d", k), NCH'(irq_line[k]), NCH'(|m_mask(k)));
    endtask

    task automatic wr(input int a, input logic [NCH-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            0, 3, 6: m_raw = m_raw & ~d;
            1: m_en[0] = d;
            2: m_frc[0] = d;
            4: m_en[1] = d;
            5: m_frc[1] = d;
            default: ;
        endcase
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        ch_done = m;
        @(negedge clk);
        ch_done = '0;
        m_raw = m_raw | (m & ~ch_quiet);
    endtask

    // Pulse and clear in the same cycle
    task automatic collide(input logic [NCH-1:0] m, input logic [NCH-1:0] c, input int a);
        @(negedge clk);
        ch_done = m; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = c;
        @(negedge clk);
        ch_done = '0; bus_wr = 1'b0;
        m_raw = (m_raw & ~c) | (m & ~ch_quiet);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NL; k++) begin m_en[k] = '0; m_frc[k] = '0; end
        repeat (4) @(negedge clk);
        check_all("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R2/R4/R5: walk every channel, clear through alternating addresses
        for (int ch = 0; ch < NCH; ch++) begin
            wr(1, NCH'(1) << ch);
            wr(4, ~(NCH'(1) << ch));
            pulse(NCH'(1) << ch);
            check_all("R2 set");
            wr((ch % 3 == 0) ? 0 : ((ch % 3 == 1) ? 3 : 6), NCH'(1) << ch);
            check_all((ch % 3 == 0) ? "R4 clear" : "R5 clear via masked");
        end

        // R4: partial clear keeps the other bits
        pulse(16'hFFFF);
        wr(0, 16'h0F0F);
        check_all("R4 partial");
        wr(6, 16'hF000);
        check_all("R5 partial");
        wr(0, 16'hFFFF);

        // R3: quiet patterns block posting
        for (int p = 0; p < 4; p++) begin
            ch_quiet = (p == 0) ? 16'hA5A5 : (p == 1) ? 16'h5A5A : (p == 2) ? 16'hFFFF : 16'h0001;
            pulse(16'hFFFF);
            check_all("R3 quiet");
            wr(0, 16'hFFFF);
        end
        ch_quiet = '0;

        // R9: force per line, raw untouched
        wr(1, 16'hFFFF);
        wr(4, 16'h00FF);
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2, NCH'(1) << ch);
            wr(5, NCH'(1) << (NCH - 1 - ch));
            check_all("R9 force");
        end
        pulse(16'h8000);
        wr(2, '0);
        check_all("R9 force cleared");
        wr(5, '0);
        wr(0, 16'hFFFF);
        check_all("R9 raw unaffected by force");

        // R6: collision per bit, via raw and masked addresses
        for (int ch = 0; ch < NCH; ch++) begin
            pulse(16'hFFFF);
            collide(NCH'(1) << ch, 16'hFFFF, (ch % 2 == 0) ? 0 : 3);
            check_all("R6 collision");
        end
        wr(0, 16'hFFFF);

        // R10: unused address write ignored
        pulse(16'h1234);
        wr(7, 16'hFFFF);
        check_all("R10 unused addr");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule